// File: doc/BRIEF.md
# MDIO Station Management Controller

This block is the management-bus master of an Ethernet MAC. It reads and writes the 16-bit registers of a PHY over a two-wire bus: a management clock (MDC) that it generates, and a bidirectional data line (MDIO). The data line is split into an output value, an output enable and an input, so the pad buffer stays outside the block.

Software works through two registers. A control word holds a busy bit, a write bit, a three-bit clock-range code, a five-bit register address and a five-bit PHY address. A data register holds the 16-bit value. For a write, software loads the value first, then writes a control word with the busy bit set. For a read, it writes only the control word. It then polls the busy bit. When busy returns to zero, a write has completed, or the read value sits in the data register.

The clock-range code sets the MDC speed. It is loaded only by a control word whose busy bit is zero, so a driver can issue commands without tracking the speed setting.

Top module: `mdio_mgmt`

## Requirements
- R1: After reset the control word reads 0 and the data register reads 0. MDC, the MDIO output value and the MDIO output enable are all low.
- R2: A control-word write with bit 0 (busy) set starts one frame. From the next clock, bit 0 reads 1. During the frame MDC rises exactly 64 times, and bit 0 returns to 0 in the clock where MDC falls after its 64th rise.
- R3: On the rising edges of MDC the frame presents, in order:
  - 32 ones;
  - the start pattern 0 then 1;
  - the opcode, 0 then 1 for a write or 1 then 0 for a read;
  - the PHY address from control bits 14:10, MSB first;
  - the register address from control bits 9:5, MSB first.
  After the frame, the control word reads back the issued write flag and both address fields, with bit 0 clear.
- R4: Control bit 1 set selects a write frame. It presents turnaround 1 then 0, followed by the data register's 16 bits MSB first. The MDIO output enable is high for all 64 bits.
- R5: Control bit 1 clear selects a read frame. The MDIO output enable is low for the final 18 bits. The 16 bits sampled from MDIO at the last 16 MDC rising edges are placed in the data register, MSB first, by the time bit 0 reads 0.
- R6: For clock-range code c in control bits 4:2, MDC stays high for (c+1)·HALF_UNIT clocks and low for the same number of clocks, so its period is 2·(c+1)·HALF_UNIT clocks.
- R7: A control-word write with bit 0 clear loads the clock-range code. A write with bit 0 set leaves the code unchanged.
- R8: While bit 0 reads 1, writes to the control word and to the data register have no effect.
- R9: PHY address 0 and every register address from 0 to 31 are accepted and sent unchanged.
- R10: While no frame is in progress, MDC and the MDIO output enable stay low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 1 | Write target: 0 selects the control word, 1 selects the data register |
| reg_wdata | input | 32 | Write value |
| ctrl_rd | output | 32 | Control word readback |
| data_rd | output | 16 | Data register readback |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | MDIO output value |
| mdio_oe | output | 1 | MDIO output enable |
| mdio_i | input | 1 | MDIO input from the pad |

## Verification
Some properties are checked on every cycle:
- busy clears only on a frame-completion pulse;
- MDC is low whenever busy is clear;
- the data register and the clock-range code hold while a frame runs;
- a new frame starts only from idle;
- the divider emits edges only inside a frame.

Other properties can only be shown by the bench's scenarios, which sample the line at each rising edge of MDC:
- the exact bit order of each frame and the output-enable pattern of reads and writes;
- the MDC period for each range code;
- that writes issued mid-frame leave no trace afterwards.

// File: rtl/mdio_mgmt_pkg.sv
package mdio_mgmt_pkg;
    // Frame layout (bit positions counted from the first preamble bit)
    localparam int PRE_BITS   = 32;
    localparam int FRAME_BITS = PRE_BITS + 32;
    localparam int TA_POS     = PRE_BITS + 14;
    localparam int DATA_POS   = PRE_BITS + 16;
    localparam int IDX_W      = $clog2(FRAME_BITS);

    // Control word fields
    localparam int REG_W     = 32;
    localparam int DW        = 16;
    localparam int AW        = 5;
    localparam int CR_W      = 3;
    localparam int BUSY_BIT  = 0;
    localparam int WRITE_BIT = 1;
    localparam int CR_LSB    = 2;
    localparam int RA_LSB    = 5;
    localparam int PA_LSB    = 10;

    typedef struct packed {
        logic            busy;
        logic            write;
        logic [CR_W-1:0] cr;
        logic [AW-1:0]   phy;
        logic [AW-1:0]   ra;
        logic [DW-1:0]   data;
    } ctl_regs_t;

    typedef struct packed {
        logic                  active;
        logic                  write;
        logic [IDX_W-1:0]      idx;
        logic [FRAME_BITS-1:0] sh;
        logic [DW-1:0]         cap;
    } frame_st_t;
endpackage

// File: rtl/mdio_mgmt_clkgen.sv
module mdio_mgmt_clkgen #(
    parameter int HALF_UNIT = 2,
    parameter int CR_W      = 3
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            en_i,
    input  logic [CR_W-1:0] range_i,
    output logic            mdc_o,
    output logic            rise_o,
    output logic            fall_o
);
    localparam int CNT_W = $clog2(HALF_UNIT * (1 << CR_W)) + 1;

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             mdc;
    } div_st_t;

    div_st_t          st_d, st_q;
    logic [CNT_W-1:0] half_len;
    logic             wrap;

    always_comb begin
        half_len = (CNT_W'(range_i) + CNT_W'(1)) * CNT_W'(HALF_UNIT);
        wrap     = en_i && (st_q.cnt == half_len - CNT_W'(1));
        rise_o   = wrap && !st_q.mdc;
        fall_o   = wrap && st_q.mdc;
        st_d     = st_q;
        if (!en_i) begin
            st_d.cnt = '0;
            st_d.mdc = 1'b0;
        end else if (wrap) begin
            st_d.cnt = '0;
            st_d.mdc = !st_q.mdc;
        end else begin
            st_d.cnt = st_q.cnt + CNT_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign mdc_o = st_q.mdc;
endmodule

// File: rtl/mdio_mgmt_frame.sv
module mdio_mgmt_frame
    import mdio_mgmt_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start_i,
    input  logic          write_i,
    input  logic [AW-1:0] phy_i,
    input  logic [AW-1:0] ra_i,
    input  logic [DW-1:0] wdata_i,
    input  logic          rise_i,
    input  logic          fall_i,
    input  logic          mdio_i,
    output logic          active_o,
    output logic          mdio_o,
    output logic          mdio_oe,
    output logic          done_o,
    output logic [DW-1:0] rdata_o
);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(FRAME_BITS - 1);
    localparam logic [IDX_W-1:0] TA_IDX   = IDX_W'(TA_POS);
    localparam logic [IDX_W-1:0] DATA_IDX = IDX_W'(DATA_POS);

    frame_st_t st_d, st_q;

    always_comb begin
        st_d   = st_q;
        done_o = 1'b0;
        if (start_i) begin
            st_d.active = 1'b1;
            st_d.write  = write_i;
            st_d.idx    = '0;
            st_d.cap    = '0;
            st_d.sh     = {{PRE_BITS{1'b1}}, 2'b01,
                           (write_i ? 2'b01 : 2'b10),
                           phy_i, ra_i,
                           (write_i ? 2'b10 : 2'b00),
                           (write_i ? wdata_i : {DW{1'b0}})};
        end else if (st_q.active) begin
            if (rise_i && !st_q.write && st_q.idx >= DATA_IDX)
                st_d.cap = {st_q.cap[DW-2:0], mdio_i};
            if (fall_i) begin
                if (st_q.idx == LAST_IDX) begin
                    st_d.active = 1'b0;
                    done_o      = 1'b1;
                end else begin
                    st_d.idx = st_q.idx + IDX_W'(1);
                    st_d.sh  = {st_q.sh[FRAME_BITS-2:0], 1'b0};
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign active_o = st_q.active;
    assign mdio_o   = st_q.active && st_q.sh[FRAME_BITS-1];
    assign mdio_oe  = st_q.active && (st_q.write || st_q.idx < TA_IDX);
    assign rdata_o  = st_q.cap;

    // R2
    start_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |-> !st_q.active);
    // R6
    edge_in_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rise_i || fall_i) |-> st_q.active);
endmodule

// File: rtl/mdio_mgmt.sv
module mdio_mgmt
    import mdio_mgmt_pkg::*;
#(
    parameter int HALF_UNIT = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             reg_wr,
    input  logic             reg_sel,
    input  logic [REG_W-1:0] reg_wdata,
    output logic [REG_W-1:0] ctrl_rd,
    output logic [DW-1:0]    data_rd,
    output logic             mdc,
    output logic             mdio_o,
    output logic             mdio_oe,
    input  logic             mdio_i
);
    ctl_regs_t     regs_d, regs_q;
    logic          launch;
    logic          frame_done;
    logic          frame_active;
    logic          rise_stb, fall_stb;
    logic [DW-1:0] frame_rdata;

    always_comb begin
        regs_d = regs_q;
        launch = 1'b0;
        if (frame_done) begin
            regs_d.busy = 1'b0;
            if (!regs_q.write) regs_d.data = frame_rdata;
        end else if (reg_wr && !regs_q.busy) begin
            if (!reg_sel) begin
                regs_d.write = reg_wdata[WRITE_BIT];
                regs_d.phy   = reg_wdata[PA_LSB +: AW];
                regs_d.ra    = reg_wdata[RA_LSB +: AW];
                if (reg_wdata[BUSY_BIT]) begin
                    regs_d.busy = 1'b1;
                    launch      = 1'b1;
                end else begin
                    regs_d.cr = reg_wdata[CR_LSB +: CR_W];
                end
            end else begin
                regs_d.data = reg_wdata[DW-1:0];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) regs_q <= '0;
        else        regs_q <= regs_d;
    end

    always_comb begin
        ctrl_rd                    = '0;
        ctrl_rd[BUSY_BIT]          = regs_q.busy;
        ctrl_rd[WRITE_BIT]         = regs_q.write;
        ctrl_rd[CR_LSB +: CR_W]    = regs_q.cr;
        ctrl_rd[RA_LSB +: AW]      = regs_q.ra;
        ctrl_rd[PA_LSB +: AW]      = regs_q.phy;
    end
    assign data_rd = regs_q.data;

    mdio_mgmt_clkgen #(.HALF_UNIT(HALF_UNIT), .CR_W(CR_W)) u_clkgen (
        .clk     (clk),
        .rst_n   (rst_n),
        .en_i    (frame_active),
        .range_i (regs_q.cr),
        .mdc_o   (mdc),
        .rise_o  (rise_stb),
        .fall_o  (fall_stb)
    );

    mdio_mgmt_frame u_frame (
        .clk      (clk),
        .rst_n    (rst_n),
        .start_i  (launch),
        .write_i  (reg_wdata[WRITE_BIT]),
        .phy_i    (reg_wdata[PA_LSB +: AW]),
        .ra_i     (reg_wdata[RA_LSB +: AW]),
        .wdata_i  (regs_q.data),
        .rise_i   (rise_stb),
        .fall_i   (fall_stb),
        .mdio_i   (mdio_i),
        .active_o (frame_active),
        .mdio_o   (mdio_o),
        .mdio_oe  (mdio_oe),
        .done_o   (frame_done),
        .rdata_o  (frame_rdata)
    );

    // R2
    busy_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(regs_q.busy) |-> $past(frame_done));
    // R10
    idle_mdc_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !regs_q.busy |-> (!mdc && !mdio_oe));
    // R8
    busy_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (regs_q.busy && $past(regs_q.busy)) |-> $stable(regs_q.data));
    // R7
    cr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        regs_q.busy |-> $stable(regs_q.cr));
endmodule

// File: tb/mdio_mgmt_bench.sv
`timescale 1ns/1ps
module mdio_mgmt_bench;
    localparam int HU = 2;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic        reg_sel = 1'b0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] ctrl_rd;
    logic [15:0] data_rd;
    logic        mdc, mdio_o, mdio_oe;
    logic        mdio_i = 1'b1;

    int checks = 0;
    int failures = 0;

    always #5 clk = ~clk;

    mdio_mgmt #(.HALF_UNIT(HU)) u_mdio_mgmt (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_sel(reg_sel),
        .reg_wdata(reg_wdata), .ctrl_rd(ctrl_rd), .data_rd(data_rd),
        .mdc(mdc), .mdio_o(mdio_o), .mdio_oe(mdio_oe), .mdio_i(mdio_i)
    );

    // PHY-side observer and responder
    logic [63:0] cap_o, cap_oe;
    logic [15:0] resp;
    int          k = 0;
    realtime     t_r0, t_r1;

    always @(posedge mdc) begin
        if (k < 64) begin
            cap_o[63-k]  = mdio_o;
            cap_oe[63-k] = mdio_oe;
        end
        if (k == 0) t_r0 = $realtime;
        if (k == 1) t_r1 = $realtime;
        k = k + 1;
    end

    always @(negedge mdc) begin
        if (k >= 48 && k < 64) mdio_i <= resp[63-k];
        else                   mdio_i <= 1'b1;
    end

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [63:0] exp_frame(input logic wr, input logic [4:0] pa,
                                              input logic [4:0] ra, input logic [15:0] d);
        return {32'hFFFF_FFFF, 2'b01, (wr ? 2'b01 : 2'b10), pa, ra,
                (wr ? 2'b10 : 2'b00), (wr ? d : 16'h0)};
    endfunction

    function automatic logic [63:0] exp_oe(input logic wr);
        return wr ? {64{1'b1}} : {{46{1'b1}}, 18'b0};
    endfunction

    function automatic logic [31:0] ctl_word(input logic busy, input logic wr,
                                             input logic [2:0] cr, input logic [4:0] pa,
                                             input logic [4:0] ra);
        return {17'b0, pa, ra, cr, wr, busy};
    endfunction

    task automatic write_reg(input logic sel, input logic [31:0] v);
        @(negedge clk);
        reg_wr = 1'b1; reg_sel = sel; reg_wdata = v;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic wait_idle();
        int n = 0;
        while (ctrl_rd[0] && n < 6000) begin
            @(negedge clk);
            n++;
        end
        check("R2 busy clears", 64'(ctrl_rd[0]), 64'd0);
    endtask

    // full command: optional data load, launch, wait, check frame
    task automatic run_cmd(input logic wr, input logic [4:0] pa, input logic [4:0] ra,
                           input logic [15:0] d, input logic [15:0] rsp,
                           input logic [2:0] cr_now, input logic [2:0] cr_junk);
        logic [63:0] ef, eo;
        if (wr) write_reg(1'b1, {16'h0, d});
        resp = rsp;
        k = 0;
        write_reg(1'b0, ctl_word(1'b1, wr, cr_junk, pa, ra));
        check("R2 busy set", 64'(ctrl_rd[0]), 64'd1);
        wait_idle();
        ef = exp_frame(wr, pa, ra, d);
        eo = exp_oe(wr);
        check("R2 mdc rise count", 64'(k), 64'd64);
        check(wr ? "R4 oe pattern" : "R5 oe pattern", cap_oe, eo);
        check(wr ? "R3 R4 R9 write frame" : "R3 R9 read frame", cap_o & eo, ef & eo);
        check("R3 R7 ctrl readback", 64'(ctrl_rd), 64'(ctl_word(1'b0, wr, cr_now, pa, ra)));
        check("R6 mdc period", 64'(int'((t_r1 - t_r0) / 10.0)), 64'(2 * (cr_now + 1) * HU));
        if (!wr) check("R5 read data", 64'(data_rd), 64'(rsp));
        else     check("R4 data kept", 64'(data_rd), 64'(d));
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        failures++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        logic [2:0] c;
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        // R1 reset state
        check("R1 ctrl", 64'(ctrl_rd), 64'd0);
        check("R1 data", 64'(data_rd), 64'd0);
        check("R1 pins", {61'd0, mdc, mdio_o, mdio_oe}, 64'd0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        check("R10 idle pins", {62'd0, mdc, mdio_oe}, 64'd0);

        // directed: PHY 0, register 31, write, range 0
        run_cmd(1'b1, 5'd0, 5'd31, 16'hA5C3, 16'h0, 3'd0, 3'd5);
        // directed: read PHY 31 register 0
        run_cmd(1'b0, 5'd31, 5'd0, 16'h0, 16'h8001, 3'd0, 3'd7);

        // R7: configuration write sets range 3, commands keep it
        write_reg(1'b0, ctl_word(1'b0, 1'b0, 3'd3, 5'd0, 5'd0));
        check("R7 range loaded", 64'(ctrl_rd[4:2]), 64'd3);
        run_cmd(1'b0, 5'd7, 5'd19, 16'h0, 16'h3C5A, 3'd3, 3'd1);

        // R8: writes during a frame are ignored
        write_reg(1'b1, 32'h0000_1234);
        resp = 16'h0; k = 0;
        write_reg(1'b0, ctl_word(1'b1, 1'b1, 3'd0, 5'd9, 5'd4));
        repeat (20) @(negedge clk);
        write_reg(1'b1, 32'h0000_BEEF);
        write_reg(1'b0, ctl_word(1'b0, 1'b0, 3'd6, 5'd1, 5'd2));
        write_reg(1'b0, ctl_word(1'b1, 1'b0, 3'd6, 5'd1, 5'd2));
        check("R8 data during busy", 64'(data_rd), 64'h1234);
        wait_idle();
        check("R8 frame data", cap_o[15:0], 64'h1234);
        check("R8 data after", 64'(data_rd), 64'h1234);
        check("R8 ctrl after", 64'(ctrl_rd), 64'(ctl_word(1'b0, 1'b1, 3'd3, 5'd9, 5'd4)));
        check("R8 single frame", 64'(k), 64'd64);
        repeat (40) @(negedge clk);
        check("R10 idle after", {62'd0, mdc, mdio_oe}, 64'd0);

        // random commands
        for (int i = 0; i < 14; i++) begin
            c = 3'($urandom_range(0, 3));
            write_reg(1'b0, ctl_word(1'b0, 1'b0, c, 5'd0, 5'd0));
            run_cmd(1'($urandom_range(0, 1)), 5'($urandom), 5'($urandom),
                    16'($urandom), 16'($urandom), c, 3'($urandom));
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule